// File: doc/BRIEF.md
# Write-Once System Control Register

This block is one 8-bit system control and status register on a simple register bus. Firmware uses it for three things. It declares once, early after reset, whether an external crystal is fitted. It slows the main internal oscillator. It picks how much RAM is cleared after a watchdog reset. The register also reports whether the boot routine had to run more than once since power-on.

The crystal-present field takes one write per reset and is then locked, and a read-only bit shows that the lock has happened. The field decides whether the slow clock source may leave the internal low-speed oscillator. When no crystal is declared, the registered clock-select output stays on the internal oscillator whatever firmware requests. When a crystal is declared, the output follows the firmware request one cycle later, in either direction.

There are two reset inputs. `porN` is power-on reset and clears everything. `rstN` is any other system reset, such as a watchdog reset. It clears everything except the repeated-boot history.

Top module: `sysctl_lockreg`

## Requirements
- R1: The register answers only at address 0xFE. A read at any other address returns 0x00, and a write to any other address changes nothing.
- R2: Bit 2 (crystal present, 1 = fitted) takes its value from the first write to 0xFE after reset. Later writes leave it unchanged until the next reset.
- R3: Bit 3 (lock) reads 0 after reset and reads 1 from the cycle after the first write to 0xFE. A write in the very next cycle is already treated as locked.
- R4: While bit 2 is 0, output `slowClkSel` is 0 (internal low-speed oscillator) one cycle later, whatever `clkSelReq` is.
- R5: While bit 2 is 1, `slowClkSel` equals the value `clkSelReq` had one cycle earlier (1 = crystal), in both directions.
- R6: Bit 7 (repeated boot) is 0 after power-on. It becomes 1 on the cycle after the second `bootPulse`. It survives `rstN` and is cleared only by `porN`.
- R7: Bit 4 (slow main oscillator) can be read and written freely and drives `imoSlow`, where 1 requests 6 MHz instead of 24 MHz.
- R8: Bit 0 (minimal RAM clear) can be read and written freely, resets to 0 (full clear to 0x00), and drives `ramClearMin`.
- R9: Bits 6, 5 and 1 always read 0, and writing them has no effect. Bits 7 and 3 are read-only.
- R10: Either reset returns bits 4, 3, 2 and 0, `slowClkSel`, `imoSlow`, `ramClearMin` and `xtalPresent` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, synchronous, clears all state |
| rstN | input | 1 | System (e.g. watchdog) reset, active low, synchronous, keeps boot history |
| addr | input | 8 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr |
| bootPulse | input | 1 | One-cycle pulse at the end of each boot pass |
| clkSelReq | input | 1 | Firmware slow-clock request, 1 = crystal |
| slowClkSel | output | 1 | Registered slow-clock select, 1 = crystal |
| xtalPresent | output | 1 | Current crystal-present flag |
| imoSlow | output | 1 | Main oscillator slow request |
| ramClearMin | output | 1 | Minimal RAM clear selection |

## Verification
The assertions assume that both resets are synchronous and are held low across at least one clock edge. They also assume that `bootPulse` lasts a single cycle and that all inputs change only away from the rising edge. The bench drives every input on the falling edge, generates `bootPulse` as single-cycle pulses with idle gaps, and holds each reset for two full cycles. Random writes mix the register address with other addresses and occasionally insert a system reset, so the one-write lock is exercised again after each reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int BIT_RAMMIN  = 0;
  localparam int BIT_XTAL    = 2;
  localparam int BIT_LOCK    = 3;
  localparam int BIT_IMOSLOW = 4;
  localparam int BIT_REPBOOT = 7;

  localparam logic [7:0] RSVD_MASK   = 8'b0110_0010;
  localparam logic [7:0] IGNORE_MASK = 8'b1110_1010;

  typedef struct packed {
    logic regHit;
    logic regWr;
    logic xtalWr;
  } ctlStrobe_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFE
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              bootPulse,
  output ctlStrobe_t        strobe,
  output logic              locked,
  output logic              repeatBoot
);

  logic bootSeen;

  always_comb begin
    strobe.regHit = (addr == REG_ADDR);
    strobe.regWr  = strobe.regHit && wrEn;
    strobe.xtalWr = strobe.regWr && !locked;
  end

  // R3: the lock is set by any write to the register and held until reset
  always_ff @(posedge clk) begin
    if (!sysRstN)          locked <= 1'b0;
    else if (strobe.regWr) locked <= 1'b1;
  end

  // R6: boot history only follows power-on reset
  always_ff @(posedge clk) begin
    if (!porN) begin
      bootSeen   <= 1'b0;
      repeatBoot <= 1'b0;
    end else if (bootPulse) begin
      bootSeen <= 1'b1;
      if (bootSeen) repeatBoot <= 1'b1;
    end
  end

  a_r3_lock_after_write: assert property (@(posedge clk) disable iff (!sysRstN)
    strobe.regWr |=> locked);

  a_r6_repeat_sticky: assert property (@(posedge clk) disable iff (!porN)
    repeatBoot |=> repeatBoot);

  a_r6_second_pass: assert property (@(posedge clk) disable iff (!porN)
    (bootSeen && bootPulse) |=> repeatBoot);

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  ctlStrobe_t        strobe,
  input  logic              wrXtal,
  input  logic              wrImo,
  input  logic              wrRam,
  input  logic              locked,
  input  logic              repeatBoot,
  input  logic              clkSelReq,
  output logic [DATA_W-1:0] rdData,
  output logic              xtalPresent,
  output logic              slowClkSel,
  output logic              imoSlow,
  output logic              ramClearMin
);

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      xtalPresent <= 1'b0;
      imoSlow     <= 1'b0;
      ramClearMin <= 1'b0;
      slowClkSel  <= 1'b0;
    end else begin
      if (strobe.xtalWr) xtalPresent <= wrXtal;
      if (strobe.regWr) begin
        imoSlow     <= wrImo;
        ramClearMin <= wrRam;
      end
      // R4/R5: registered gate of the firmware request by the crystal flag
      slowClkSel <= xtalPresent && clkSelReq;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.regHit) begin
      rdData[BIT_REPBOOT] = repeatBoot;
      rdData[BIT_IMOSLOW] = imoSlow;
      rdData[BIT_LOCK]    = locked;
      rdData[BIT_XTAL]    = xtalPresent;
      rdData[BIT_RAMMIN]  = ramClearMin;
    end
  end

  a_r4_forced_internal: assert property (@(posedge clk) disable iff (!sysRstN)
    !xtalPresent |=> !slowClkSel);

  a_r5_follows_request: assert property (@(posedge clk) disable iff (!sysRstN)
    xtalPresent |=> (slowClkSel == $past(clkSelReq)));

  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!sysRstN)
    locked |=> $stable(xtalPresent));

endmodule

// File: rtl/sysctl_lockreg.sv
module sysctl_lockreg
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFE
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              bootPulse,
  input  logic              clkSelReq,
  output logic              slowClkSel,
  output logic              xtalPresent,
  output logic              imoSlow,
  output logic              ramClearMin
);

  logic       sysRstN;
  logic       locked;
  logic       repeatBoot;
  ctlStrobe_t strobe;

  assign sysRstN = porN && rstN;

  sysctl_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .addr(addr), .wrEn(wrEn),
    .bootPulse(bootPulse), .strobe(strobe), .locked(locked),
    .repeatBoot(repeatBoot)
  );

  sysctl_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .sysRstN(sysRstN), .strobe(strobe),
    .wrXtal(wrData[BIT_XTAL]), .wrImo(wrData[BIT_IMOSLOW]),
    .wrRam(wrData[BIT_RAMMIN]), .locked(locked), .repeatBoot(repeatBoot),
    .clkSelReq(clkSelReq), .rdData(rdData), .xtalPresent(xtalPresent),
    .slowClkSel(slowClkSel), .imoSlow(imoSlow), .ramClearMin(ramClearMin)
  );

  // R9: writing reserved or read-only bits never makes reserved bits read back
  a_r9_ignored_bits: assert property (@(posedge clk) disable iff (!sysRstN)
    (strobe.regWr && |(wrData[7:0] & IGNORE_MASK))
      |=> (addr != REG_ADDR || (rdData[7:0] & RSVD_MASK) == 8'h00));

  // R1: no decode outside the register address
  a_r1_other_addr_zero: assert property (@(posedge clk) disable iff (!sysRstN)
    (addr != REG_ADDR) |-> (rdData == '0));

endmodule

// File: tb/sysctl_lockreg_tb.sv
module sysctl_lockreg_tb;

  logic       clk = 1'b0;
  logic       porN, rstN, wrEn, bootPulse, clkSelReq;
  logic [7:0] addr, wrData, rdData;
  logic       slowClkSel, xtalPresent, imoSlow, ramClearMin;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic eXtal, eLock, eImo, eRam, eRep, eSel;
  int   bootCnt;

  always #2 clk = ~clk;

  sysctl_lockreg u_dut (
    .clk(clk), .porN(porN), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .bootPulse(bootPulse),
    .clkSelReq(clkSelReq), .slowClkSel(slowClkSel), .xtalPresent(xtalPresent),
    .imoSlow(imoSlow), .ramClearMin(ramClearMin)
  );

  function automatic logic [7:0] expByte();
    return {eRep, 2'b00, eImo, eLock, eXtal, 1'b0, eRam};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(logic [7:0] a, logic we, logic [7:0] wd, logic bp, logic rq);
    @(negedge clk);
    addr = a; wrEn = we; wrData = wd; bootPulse = bp; clkSelReq = rq;
    @(posedge clk);
    #1;
    eSel = eXtal & rq;
    if (we && a == 8'hFE) begin
      if (!eLock) begin eXtal = wd[2]; eLock = 1'b1; end
      eImo = wd[4];
      eRam = wd[0];
    end
    if (bp) begin
      bootCnt++;
      if (bootCnt >= 2) eRep = 1'b1;
    end
  endtask

  task automatic readChk(string tag);
    @(negedge clk);
    wrEn = 1'b0; bootPulse = 1'b0;
    addr = 8'hFE;
    #1;
    chk({tag, " R2/R3/R6/R9 rdData"}, rdData, expByte());
    chk({tag, " R4/R5 slowClkSel"}, {7'd0, slowClkSel}, {7'd0, eSel});
    chk({tag, " R7 imoSlow"}, {7'd0, imoSlow}, {7'd0, eImo});
    chk({tag, " R8 ramClearMin"}, {7'd0, ramClearMin}, {7'd0, eRam});
    addr = 8'h3C;
    #1;
    chk({tag, " R1 other address"}, rdData, 8'h00);
  endtask

  task automatic clearCfg();
    eXtal = 0; eLock = 0; eImo = 0; eRam = 0; eSel = 0;
  endtask

  task automatic doSysReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; bootPulse = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    clearCfg();
  endtask

  task automatic doPor();
    @(negedge clk);
    porN = 1'b0; wrEn = 1'b0; bootPulse = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    porN = 1'b1;
    clearCfg();
    eRep = 0; bootCnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int dummy;
    porN = 0; rstN = 1; addr = 0; wrEn = 0; wrData = 0; bootPulse = 0; clkSelReq = 0;
    dummy = $urandom(32'd1234);
    doPor();
    readChk("reset R10");

    // R2/R3: first write locks; back-to-back write already sees the lock
    cycle(8'hFE, 1, 8'h04, 0, 0);
    cycle(8'hFE, 1, 8'h00, 0, 0);
    readChk("R2 back-to-back");
    cycle(8'hFE, 0, 8'h00, 0, 1);
    readChk("R5 to crystal");
    cycle(8'hFE, 0, 8'h00, 0, 0);
    readChk("R5 to internal");

    // R10 then R4
    doSysReset();
    readChk("R10 system reset");
    cycle(8'h10, 1, 8'h04, 0, 1);
    readChk("R1 write elsewhere");
    cycle(8'hFE, 1, 8'h00, 0, 1);
    cycle(8'hFE, 1, 8'h04, 0, 1);
    cycle(8'hFE, 0, 8'h00, 0, 1);
    readChk("R4 no crystal");

    // R7/R8/R9
    cycle(8'hFE, 1, 8'hFF, 0, 1);
    readChk("R9 all ones");
    cycle(8'hFE, 1, 8'h00, 0, 0);
    readChk("R7 R8 cleared");

    // R6
    cycle(8'hFE, 0, 8'h00, 1, 0);
    cycle(8'hFE, 0, 8'h00, 0, 0);
    readChk("R6 one pass");
    cycle(8'hFE, 0, 8'h00, 1, 0);
    readChk("R6 second pass");
    doSysReset();
    readChk("R6 survives rstN");
    doPor();
    readChk("R6 cleared by porN");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = ($urandom % 3 == 0) ? 8'($urandom) : 8'hFE;
      if (i % 60 == 59) doSysReset();
      cycle(a, 1'($urandom), 8'($urandom), ($urandom % 9 == 0), 1'($urandom));
      readChk("random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule